// File: doc/BRIEF.md
# Configurable Serial Frame Receiver

This block receives serial characters from a single line. Each frame is a low start bit, then 5 to 9 data bits sent least significant bit first, then an optional parity bit, then a high stop bit. Software sets the frame format with three controls: a 3-bit size code, a 2-bit parity mode and a mode select. In asynchronous mode a free-running oversampling tick, sixteen ticks per bit, paces the receiver, and the line is judged by majority vote at mid-bit. In synchronous mode the line is sampled on one edge of an external clock. The polarity control chooses that edge.

A finished character goes into a single receive buffer. The low eight bits and the ninth bit come out on separate outputs. Three error flags travel with the stored character: frame error, parity error and overrun. A receive-complete flag is set when a character is stored and cleared by a read strobe. The interrupt output is the receive-complete flag masked by a local enable and a global enable. Dropping the receiver enable throws away the buffered character and every flag. Baud-rate generation and the register interface sit outside the block.

Top module: `ser_frame_rx`

## Requirements
- R1: The size code sets the number of data bits: 000 gives 5, 001 gives 6, 010 gives 7, 011 gives 8 and 111 gives 9. The reserved codes 100 to 110 give 8. Data arrive LSB first, and buffer bits above the character width read as zero.
- R2: The parity mode 00 means no parity bit. The reserved mode 01 behaves the same way.
- R3: The parity mode 10 expects even parity and 11 expects odd parity, counted over the data bits plus the parity bit. A mismatch sets the parity-error flag for that character, and a match clears it.
- R4: Only one stop bit is checked. A stop bit that samples low sets the frame-error flag. A new start bit may follow a single stop bit at once.
- R5: In asynchronous mode a start bit counts only if the majority of oversampling samples 7, 8 and 9 after the falling edge is low. Each data bit is the majority of its three middle samples, so a one-sample glitch has no effect.
- R6: In synchronous mode, polarity 0 samples the line on the falling edge of the external clock and polarity 1 samples it on the rising edge.
- R7: Storing a character sets the receive-complete flag. A one-cycle read strobe clears it, and reset clears it.
- R8: If a character completes while the receive-complete flag is still set, the overrun flag is set and the buffer keeps the older character.
- R9: In 9-bit frames the ninth bit appears on its own output. Both data outputs stay unchanged until the next character is stored, so the ninth bit is still valid when the low byte is read.
- R10: Dropping the receiver enable clears the buffer, the receive-complete flag and all three error flags one cycle later.
- R11: The interrupt output is high exactly when the receive-complete flag, the receive interrupt enable and the global interrupt enable are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable; low flushes the buffer and flags |
| sync_mode | input | 1 | 0 selects asynchronous oversampling, 1 selects external-clock sampling |
| clk_pol | input | 1 | Synchronous sampling edge: 0 falling, 1 rising |
| size_code | input | 3 | Character size code |
| par_mode | input | 2 | Parity mode code |
| os_tick | input | 1 | Oversampling tick, 16 per bit time |
| ext_clk | input | 1 | External serial clock for synchronous mode |
| rxd | input | 1 | Serial receive line, idle high |
| rd_low | input | 1 | Read strobe for the low byte; clears receive-complete |
| rxc_ie | input | 1 | Receive-complete interrupt enable |
| gie | input | 1 | Global interrupt enable |
| data_lo | output | 8 | Low eight bits of the buffered character |
| data_b8 | output | 1 | Ninth bit of the buffered character |
| rxc | output | 1 | Receive-complete flag |
| fe | output | 1 | Frame-error flag |
| dor | output | 1 | Data-overrun flag |
| upe | output | 1 | Parity-error flag |
| irq | output | 1 | Masked receive-complete interrupt |

## Verification
A bit counter or frame state that has gone wrong shows at the ports within one frame. The character comes out shifted or truncated, the parity or frame flag settles on the wrong value, or the receive-complete flag never rises. A bad oversampling phase turns a single-sample glitch or a short start pulse into a false character or a corrupted bit, and the buffer shows it one stop-bit midpoint later. Errors in flag bookkeeping show as soon as the next character arrives: a missing overrun, a buffer overwritten while still unread, or flags that survive a disable.

// File: rtl/ser_frame_rx.sv
module ser_frame_rx #(
  parameter int OS_RATE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_en,
  input  logic       sync_mode,
  input  logic       clk_pol,
  input  logic [2:0] size_code,
  input  logic [1:0] par_mode,
  input  logic       os_tick,
  input  logic       ext_clk,
  input  logic       rxd,
  input  logic       rd_low,
  input  logic       rxc_ie,
  input  logic       gie,
  output logic [7:0] data_lo,
  output logic       data_b8,
  output logic       rxc,
  output logic       fe,
  output logic       dor,
  output logic       upe,
  output logic       irq
);
  localparam int CW  = $clog2(OS_RATE);
  localparam int MID = OS_RATE / 2 + 1;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t        state;
  logic [1:0] rx_q, ck_q, hist;
  logic       ck_d, pbit;
  logic [CW-1:0] cnt;
  logic [3:0] bidx, nb;
  logic [8:0] sreg, rbuf;

  always_comb
    case (size_code)
      3'b000:  nb = 4'd5;
      3'b001:  nb = 4'd6;
      3'b010:  nb = 4'd7;
      3'b111:  nb = 4'd9;
      default: nb = 4'd8;
    endcase

  wire rxs     = rx_q[1];
  wire ck_edge = (ck_q[1] != ck_d) && (ck_q[1] == clk_pol);
  wire maj     = (hist[1] & hist[0]) | (hist[1] & rxs) | (hist[0] & rxs);
  wire strobe  = sync_mode ? ck_edge : (os_tick && cnt == CW'(MID));
  wire bitv    = sync_mode ? rxs : maj;
  wire done    = (state == S_STOP) && strobe;
  wire perr    = par_mode[1] && ((^sreg ^ pbit) != par_mode[0]);

  assign data_lo = rbuf[7:0];
  assign data_b8 = rbuf[8];
  assign irq     = rxc & rxc_ie & gie;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_q <= 2'b11;
      ck_q <= 2'b00;
      ck_d <= 1'b0;
    end else begin
      rx_q <= {rx_q[0], rxd};
      ck_q <= {ck_q[0], ext_clk};
      ck_d <= ck_q[1];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE; cnt <= '0; hist <= 2'b11; bidx <= '0; sreg <= '0; pbit <= 1'b0;
      rbuf <= '0; rxc <= 1'b0; fe <= 1'b0; dor <= 1'b0; upe <= 1'b0;
    end else if (!rx_en) begin
      state <= S_IDLE; cnt <= '0; hist <= 2'b11; bidx <= '0; sreg <= '0; pbit <= 1'b0;
      rbuf <= '0; rxc <= 1'b0; fe <= 1'b0; dor <= 1'b0; upe <= 1'b0;
    end else begin
      if (os_tick) begin
        hist <= {hist[0], rxs};
        if (state == S_IDLE)                cnt <= CW'(1);
        else if (cnt == CW'(OS_RATE - 1))   cnt <= '0;
        else                                cnt <= cnt + 1'b1;
      end
      case (state)
        S_IDLE:
          if (sync_mode ? (strobe && !rxs) : (os_tick && !rxs)) begin
            state <= sync_mode ? S_DATA : S_START;
            sreg  <= '0;
            bidx  <= '0;
          end
        S_START:
          if (strobe) state <= bitv ? S_IDLE : S_DATA;
        S_DATA:
          if (strobe) begin
            sreg <= sreg | (9'(bitv) << bidx);
            bidx <= bidx + 1'b1;
            if (bidx == nb - 1'b1) state <= par_mode[1] ? S_PAR : S_STOP;
          end
        S_PAR:
          if (strobe) begin
            pbit  <= bitv;
            state <= S_STOP;
          end
        S_STOP:
          if (strobe) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
      if (done) begin
        if (rxc && !rd_low) dor <= 1'b1;
        else begin
          rbuf <= sreg;
          fe   <= ~bitv;
          upe  <= perr;
          dor  <= 1'b0;
          rxc  <= 1'b1;
        end
      end else if (rd_low) rxc <= 1'b0;
    end

  a_r10_flush: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!rxc && !fe && !dor && !upe && data_lo == 8'h00 && !data_b8));

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && rd_low && !done) |=> !rxc);

  a_r8_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && done && rxc && !rd_low) |=> (dor && $stable(data_lo) && $stable(data_b8)));

  a_r9_buffer_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && rxc && !done) |=> ($stable(data_lo) && $stable(data_b8)));

  a_r11_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rxc && gie && rxc_ie));
endmodule

// File: tb/ser_frame_rx_test.sv
`timescale 1ns/1ps
module ser_frame_rx_test;
  logic clk = 1'b0, rst_n = 1'b0, rx_en = 1'b1, sync_mode = 1'b0, clk_pol = 1'b0;
  logic [2:0] size_code = 3'b011;
  logic [1:0] par_mode = 2'b00;
  logic os_tick = 1'b0, ext_clk = 1'b0, rxd = 1'b1, rd_low = 1'b0, rxc_ie = 1'b0, gie = 1'b0;
  logic [7:0] data_lo;
  logic data_b8, rxc, fe, dor, upe, irq;
  int checks = 0, errors = 0;

  ser_frame_rx uut (.*);

  always #2.5 clk = ~clk;

  initial forever begin
    @(negedge clk) os_tick = 1'b1;
    @(negedge clk) os_tick = 1'b0;
    repeat (2) @(negedge clk);
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hold(logic v, int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  // pm: 0 none, 2 even, 3 odd; gb: data bit with a 4-clock glitch, -1 none
  task automatic send_async(logic [8:0] d, int n, int pm, bit badpar, bit stopv, int gap, int gb);
    hold(1'b0, 64);
    for (int i = 0; i < n; i++) begin
      if (i == gb) begin
        hold(d[i], 32); hold(~d[i], 4); hold(d[i], 28);
      end else hold(d[i], 64);
    end
    if (pm >= 2) begin
      logic p;
      p = 1'b0;
      for (int i = 0; i < n; i++) p ^= d[i];
      hold(p ^ pm[0] ^ badpar, 64);
    end
    hold(stopv, 64);
    hold(1'b1, gap);
  endtask

  task automatic send_sync(logic [7:0] d);
    logic [9:0] f;
    f = {1'b1, d, 1'b0};
    for (int i = 0; i < 10; i++) begin
      ext_clk = ~clk_pol;
      repeat (2) @(negedge clk);
      rxd = f[i];
      repeat (6) @(negedge clk);
      ext_clk = clk_pol;
      repeat (8) @(negedge clk);
    end
    repeat (10) @(negedge clk);
  endtask

  task automatic do_read;
    rd_low = 1'b1; @(negedge clk); rd_low = 1'b0; @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R7 reset rxc", rxc, 0);
    chk("R10 reset flags", {fe, dor, upe}, 0);
    chk("R11 reset irq", irq, 0);
  endtask

  task automatic t_basic;
    send_async(9'h0A5, 8, 0, 0, 1, 20, -1);
    chk("R1 8-bit data", data_lo, 8'hA5);
    chk("R7 rxc set", rxc, 1);
    chk("R4 no frame error", fe, 0);
    do_read;
    chk("R7 read clears rxc", rxc, 0);
    chk("R9 data held after read", data_lo, 8'hA5);
  endtask

  task automatic t_sizes;
    size_code = 3'b000;
    send_async(9'h016, 5, 0, 0, 1, 20, -1);
    chk("R1 5-bit data", data_lo, 8'h16);
    do_read;
    size_code = 3'b010;
    send_async(9'h07F, 7, 0, 0, 1, 20, -1);
    chk("R1 7-bit data", data_lo, 8'h7F);
    do_read;
    size_code = 3'b111; par_mode = 2'b10;
    send_async(9'h1C3, 9, 2, 0, 1, 20, -1);
    chk("R9 ninth bit", data_b8, 1);
    chk("R1 9-bit low byte", data_lo, 8'hC3);
    chk("R3 even parity ok", upe, 0);
    do_read;
    size_code = 3'b011; par_mode = 2'b00;
    send_async(9'h0FF, 8, 0, 0, 1, 20, -1);
    chk("R1 b8 zero in 8-bit", data_b8, 0);
    do_read;
  endtask

  task automatic t_parity;
    par_mode = 2'b11;
    send_async(9'h033, 8, 3, 0, 1, 20, -1);
    chk("R3 odd parity ok", upe, 0);
    chk("R3 odd data", data_lo, 8'h33);
    do_read;
    send_async(9'h033, 8, 3, 1, 1, 20, -1);
    chk("R3 odd parity error", upe, 1);
    do_read;
    par_mode = 2'b10;
    send_async(9'h071, 8, 2, 1, 1, 20, -1);
    chk("R3 even parity error", upe, 1);
    do_read;
    par_mode = 2'b01;
    send_async(9'h03C, 8, 0, 0, 1, 20, -1);
    chk("R2 reserved mode data", data_lo, 8'h3C);
    chk("R2 reserved mode no flags", {fe, upe}, 0);
    do_read;
    par_mode = 2'b00;
  endtask

  task automatic t_frame_overrun;
    send_async(9'h081, 8, 0, 0, 0, 40, -1);
    chk("R4 frame error", fe, 1);
    do_read;
    send_async(9'h011, 8, 0, 0, 1, 0, -1);
    send_async(9'h022, 8, 0, 0, 1, 20, -1);
    chk("R8 overrun flag", dor, 1);
    chk("R8 old char kept", data_lo, 8'h11);
    chk("R4 back-to-back clean", fe, 0);
    do_read;
    send_async(9'h044, 8, 0, 0, 1, 20, -1);
    chk("R8 overrun cleared on store", dor, 0);
    chk("R8 new char", data_lo, 8'h44);
    do_read;
  endtask

  task automatic t_glitch;
    hold(1'b0, 8); hold(1'b1, 200);
    chk("R5 short start rejected", rxc, 0);
    send_async(9'h0FF, 8, 0, 0, 1, 20, 0);
    chk("R5 data glitch voted out", data_lo, 8'hFF);
    do_read;
  endtask

  task automatic t_irq;
    send_async(9'h05A, 8, 0, 0, 1, 20, -1);
    rxc_ie = 1'b1; gie = 1'b0; @(negedge clk);
    chk("R11 irq masked by global", irq, 0);
    gie = 1'b1; @(negedge clk);
    chk("R11 irq asserted", irq, 1);
    rxc_ie = 1'b0; @(negedge clk);
    chk("R11 irq masked by local", irq, 0);
    rxc_ie = 1'b1;
    do_read;
    chk("R11 irq drops after read", irq, 0);
    rxc_ie = 1'b0; gie = 1'b0;
  endtask

  task automatic t_disable;
    send_async(9'h0C6, 8, 0, 0, 0, 40, -1);
    send_async(9'h039, 8, 0, 0, 1, 20, -1);
    chk("R10 pre-disable flags", {rxc, fe, dor}, 3'b111);
    rx_en = 1'b0; repeat (2) @(negedge clk);
    chk("R10 flushed flags", {rxc, fe, dor, upe}, 0);
    chk("R10 flushed data", data_lo, 0);
    rx_en = 1'b1; @(negedge clk);
  endtask

  task automatic t_sync;
    clk_pol = 1'b0; ext_clk = 1'b0; sync_mode = 1'b1;
    repeat (8) @(negedge clk);
    send_sync(8'h96);
    chk("R6 polarity 0 falling edge", data_lo, 8'h96);
    do_read;
    clk_pol = 1'b1; ext_clk = 1'b1;
    repeat (8) @(negedge clk);
    send_sync(8'h4B);
    chk("R6 polarity 1 rising edge", data_lo, 8'h4B);
    chk("R6 sync rxc", rxc, 1);
    do_read;
    sync_mode = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_basic;
    t_sizes;
    t_parity;
    t_frame_overrun;
    t_glitch;
    t_irq;
    t_disable;
    t_sync;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule